// File: doc/BRIEF.md
# Launch-Sample Timing Error Cell

This block is one delay measurement cell. On each rising clock edge a launch register toggles and sends a transition into a chain of inverters, which is the path under test. A sample register captures the chain output on the falling edge of the same clock. The time budget is therefore the high-phase width of the clock, not the full period. The sampled value is compared with the value that was launched. The mismatch is held for one cycle in a capture register and is added to a saturating error counter inside the cell.

The cell is armed by `en_i` and runs a burst of 2^BURST_LOG2 launch pulses. When BURST_LOG2 is 0, a 1-bit counter stops the cell after a single pulse. Once the burst is over, the cell stays disabled and holds its error count for readout until `clr_i` is pulsed. Zero-delay logic has no real path delay, so the `inj_i` input, which the INJECT_EN parameter allows, forces a mismatch on a chosen pulse. This lets the counting be exercised.

Top module: `timing_err_cell`

## Requirements
- R1: After reset, `err_cnt_o` is 0, `done_o` is 0 and `err_flag_o` is 0.
- R2: Launch pulses without injection give no errors. With an even or odd chain length, the sampled chain output always matches the launched value, and `err_cnt_o` stays 0.
- R3: A pulse is a rising edge at which `en_i`=1 and `done_o`=0. If `inj_i`=1 at a pulse edge k, then `err_flag_o` is 1 after edge k+1 and `err_cnt_o` has grown by exactly 1 after edge k+2.
- R4: `err_cnt_o` saturates at 2^ERR_W−1. With the defaults, 16 injected pulses read 15, not 0.
- R5: `done_o` rises at the edge of the 2^BURST_LOG2-th pulse (16 by default). While `done_o`=1, `en_i` and `inj_i` have no effect and `err_cnt_o` holds its value.
- R6: At an edge where `en_i`=0, nothing is launched, so `inj_i` has no effect on `err_cnt_o`, and the edge does not count toward the burst length.
- R7: `clr_i`=1 at a rising edge sets `err_cnt_o` to 0, `done_o` to 0 and `err_flag_o` to 0. The next enabled edges start a full new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; launch on rising edge, sample on falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Arm: launch a pulse at this rising edge unless the burst is done |
| clr_i | input | 1 | Synchronous clear of all cell state |
| inj_i | input | 1 | Force a mismatch on the pulse launched at this edge |
| err_cnt_o | output | ERR_W | Saturating error count |
| err_flag_o | output | 1 | Capture register: mismatch of the previous pulse |
| done_o | output | 1 | Burst finished; cell disabled, count held |

## Verification
The error count is driven with injection masks across full bursts. A mask with no set bits separates real comparison from spurious mismatches. Single-bit masks at the first and the last pulse expose off-by-one burst lengths and a lost final capture. Alternating masks and near-full masks tell exact counting from double counting. A full mask separates saturation from wraparound. Directed sequences with enable gaps and with stimulus after the burst check that idle and disabled edges neither launch nor count. A clear in the middle of the pipeline checks that no stale capture leaks into the new burst.

// File: rtl/timing_err_pkg.sv
package timing_err_pkg;
  function automatic int unsigned cnt_w(input int unsigned bits);
    return (bits > 0) ? bits : 1;
  endfunction
endpackage

// File: rtl/tec_path.sv
module tec_path #(
  parameter int unsigned STAGES = 4
) (
  input  logic a_i,
  output logic y_o
);
  logic [STAGES:0] node;
  assign node[0] = a_i;
  for (genvar g = 0; g < STAGES; g++) begin : g_inv
    assign node[g+1] = ~node[g];
  end
  assign y_o = node[STAGES];
endmodule

// File: rtl/tec_launch.sv
module tec_launch
  import timing_err_pkg::*;
#(
  parameter int unsigned BURST_LOG2 = 4,
  parameter bit          INJECT_EN  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic inj_i,
  output logic launch_o,
  output logic live_o,
  output logic inj_o,
  output logic done_o
);
  localparam int unsigned PW = cnt_w(BURST_LOG2);
  localparam logic [PW-1:0] LAST = PW'((1 << BURST_LOG2) - 1);

  logic [PW-1:0] pulse_q;
  logic launch_q, live_q, inj_q, done_q, run, inj_eff;

  if (INJECT_EN) begin : g_inj
    assign inj_eff = inj_i;
  end else begin : g_no_inj
    assign inj_eff = 1'b0;
  end

  assign run = en_i & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_q <= 1'b0;
      live_q   <= 1'b0;
      inj_q    <= 1'b0;
      done_q   <= 1'b0;
      pulse_q  <= '0;
    end else if (clr_i) begin
      launch_q <= 1'b0;
      live_q   <= 1'b0;
      inj_q    <= 1'b0;
      done_q   <= 1'b0;
      pulse_q  <= '0;
    end else begin
      live_q <= run;
      inj_q  <= run & inj_eff;
      if (run) begin
        launch_q <= ~launch_q;
        pulse_q  <= pulse_q + 1'b1;
        if (pulse_q == LAST) done_q <= 1'b1;
      end
    end
  end

  assign launch_o = launch_q;
  assign live_o   = live_q;
  assign inj_o    = inj_q;
  assign done_o   = done_q;

  // R5: finished burst holds the launch register and stays done
  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !clr_i |=> done_q && $stable(launch_q));
  // R6: idle edge launches nothing
  p_idle_no_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(launch_q) && !live_q);
endmodule

// File: rtl/tec_sample.sv
module tec_sample #(
  parameter int unsigned STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic live_i,
  input  logic inj_i,
  input  logic launch_i,
  input  logic path_i,
  output logic flag_o
);
  localparam logic INV_ODD = logic'(STAGES % 2);

  logic sample_q, capture_q, expected;

  // falling-edge sample: budget is the high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= 1'b0;
    else         sample_q <= live_i ? (path_i ^ inj_i) : 1'b0;
  end

  assign expected = launch_i ^ INV_ODD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     capture_q <= 1'b0;
    else if (clr_i)  capture_q <= 1'b0;
    else             capture_q <= live_i & (sample_q ^ expected);
  end

  assign flag_o = capture_q;

  // R3: a flag only follows a launched pulse
  p_flag_needs_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_q |-> $past(live_i));
  // R2: a pulse without injection never flags
  p_clean_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i && !inj_i && !clr_i |=> !capture_q);
endmodule

// File: rtl/tec_err_cnt.sv
module tec_err_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == MAX && !clr_i |=> cnt_q == MAX);
endmodule

// File: rtl/timing_err_cell.sv
module timing_err_cell #(
  parameter int unsigned ERR_W      = 4,
  parameter int unsigned BURST_LOG2 = 4,
  parameter int unsigned CHAIN_LEN  = 4,
  parameter bit          INJECT_EN  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             inj_i,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             err_flag_o,
  output logic             done_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic launch, live, inj, path_y, flag;

  tec_launch #(.BURST_LOG2(BURST_LOG2), .INJECT_EN(INJECT_EN)) u_launch (
    .clk_i, .rst_ni, .clr_i, .en_i, .inj_i,
    .launch_o(launch), .live_o(live), .inj_o(inj), .done_o
  );

  tec_path #(.STAGES(CHAIN_LEN)) u_path (.a_i(launch), .y_o(path_y));

  tec_sample #(.STAGES(CHAIN_LEN)) u_sample (
    .clk_i, .rst_ni, .clr_i, .live_i(live), .inj_i(inj),
    .launch_i(launch), .path_i(path_y), .flag_o(flag)
  );

  tec_err_cnt #(.W(ERR_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i, .inc_i(flag), .cnt_o(err_cnt_o)
  );

  assign err_flag_o = flag;

  // R3: each captured error adds exactly one below saturation
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !clr_i && err_cnt_o != CNT_MAX |=> err_cnt_o == $past(err_cnt_o) + 1'b1);
  p_count_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag && !clr_i |=> $stable(err_cnt_o));
  // R7: clear empties the cell
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> err_cnt_o == '0 && !done_o && !err_flag_o);
endmodule

// File: tb/timing_err_cell_bench.sv
module timing_err_cell_bench;
  localparam int ERR_W = 4;
  localparam int BURST = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0, inj = 1'b0;
  logic [ERR_W-1:0] cnt;
  logic flag, done;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  timing_err_cell u_timing_err_cell (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .inj_i(inj),
    .err_cnt_o(cnt), .err_flag_o(flag), .done_o(done)
  );

  // {inject mask (bit i = pulse i), expected count}
  localparam logic [20:0] VEC [7] = '{
    {16'h0000, 5'd0},   // R2
    {16'h0001, 5'd1},   // R3 first pulse
    {16'h8000, 5'd1},   // R3 last pulse
    {16'hAAAA, 5'd8},   // R3
    {16'h3FFF, 5'd14},  // R3
    {16'h7FFF, 5'd15},  // R4 exactly max
    {16'hFFFF, 5'd15}   // R4 saturate
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic i, input logic c);
    en = e; inj = i; clr = c;
    @(posedge clk); @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    check("R1 cnt", int'(cnt), 0);
    check("R1 done", int'(done), 0);
    check("R1 flag", int'(flag), 0);
    rst_n = 1'b1;
    step(0, 0, 0);

    foreach (VEC[v]) begin
      step(0, 0, 1);
      for (int p = 0; p < BURST; p++) step(1, VEC[v][5+p], 0);
      check("R5 done at burst end", int'(done), 1);
      step(0, 0, 0); step(0, 0, 0);
      check("R2/R3/R4 burst count", int'(cnt), int'(VEC[v][4:0]));
    end

    // R3 pipeline timing
    step(0, 0, 1);
    step(1, 1, 0);
    check("R3 flag not yet", int'(flag), 0);
    step(0, 0, 0);
    check("R3 flag after k+1", int'(flag), 1);
    check("R3 cnt at k+1", int'(cnt), 0);
    step(0, 0, 0);
    check("R3 cnt at k+2", int'(cnt), 1);
    check("R3 flag drops", int'(flag), 0);

    // R6 idle edges ignore injection and do not count toward burst
    step(0, 0, 1);
    for (int p = 0; p < 8; p++) step(1, 0, 0);
    for (int p = 0; p < 5; p++) step(0, 1, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("R6 idle inject ignored", int'(cnt), 0);
    check("R6 idle not counted", int'(done), 0);
    for (int p = 0; p < 7; p++) step(1, 0, 0);
    check("R6 burst not yet done", int'(done), 0);
    step(1, 0, 0);
    check("R5 done after 16th pulse", int'(done), 1);

    // R5 disabled after burst
    for (int p = 0; p < 6; p++) step(1, 1, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("R5 count held", int'(cnt), 0);
    check("R5 still done", int'(done), 1);

    // R7 clear mid-pipeline
    step(0, 0, 1);
    step(1, 1, 0); step(1, 1, 0);
    step(0, 0, 1);
    check("R7 cnt cleared", int'(cnt), 0);
    check("R7 flag cleared", int'(flag), 0);
    check("R7 done cleared", int'(done), 0);
    step(0, 0, 0); step(0, 0, 0);
    check("R7 no stale error", int'(cnt), 0);
    for (int p = 0; p < BURST; p++) step(1, p == 3, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("R7 new burst count", int'(cnt), 1);
    check("R7 new burst done", int'(done), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule